// File: doc/BRIEF.md
# Virtual Output Queue Receive Buffer

This block is the receive store for one input port of a packet switch. Incoming flits land in a shared pool of storage cells. Inside that pool the block keeps a separate linked-list queue for every pairing of virtual channel and destination output. Unused cells sit on a free list that is also chained through the per-cell next pointers. A message bound for a busy output therefore never holds back a message bound for an idle one. Storage is not partitioned: any queue can grow into any free cell.

The writer presents a flit with its channel, its destination output and an end-of-message marker. It keeps its own per-channel credit count, starting at 16 for each channel and spending one per flit sent. A scheduler outside the block watches the per-queue non-empty flags, picks a (channel, output) pair and pops that queue's head. The popped flit comes out one cycle later, together with a one-cycle credit pulse on the channel it belonged to. A write and a pop may occur in the same cycle.

Top module: `voq_buffer`

## Requirements
- R1: After reset every queue is empty (`q_nonempty` all zero), `wr_ready` is 1, and `rd_valid` and `credit_ret` are 0.
- R2: An accepted flit joins queue number `wr_vc*5 + wr_out`, and bit of that number in `q_nonempty` is 1 from the next cycle on.
- R3: Each queue returns its flits in arrival order. A pop of a non-empty queue makes `rd_valid` 1 in the next cycle, with the head flit's payload on `rd_data` and its end marker on `rd_last`.
- R4: Queues are independent. Popping one queue leaves the contents and order of every other queue unchanged.
- R5: A pop of an empty queue is ignored: `rd_valid` and `credit_ret` stay 0 in the next cycle and no flag changes.
- R6: Every successful pop of a flit from channel v raises bit v of `credit_ret`, and only that bit, for exactly the cycle in which `rd_valid` is 1.
- R7: Once all 64 cells hold flits, `wr_ready` is 0, and a write presented then is ignored.
- R8: A write and a pop in the same cycle both take effect, also when both target the same queue holding exactly one flit. The popped flit is returned and the new flit stays queued.
- R9: Cells freed by pops are reused, so the full 64-cell capacity is available again after a drain, whatever the mix of queues used before.
- R10: A write or pop naming an output index of 5 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A flit is presented for writing |
| wr_vc | input | 2 | Virtual channel of the flit |
| wr_out | input | 3 | Destination output of the flit |
| wr_last | input | 1 | Flit ends its message |
| wr_data | input | 32 | Flit payload |
| wr_ready | output | 1 | At least one free cell; a valid write is taken this cycle |
| rd_en | input | 1 | Pop request from the scheduler |
| rd_vc | input | 2 | Channel of the queue to pop |
| rd_out | input | 3 | Output of the queue to pop |
| rd_valid | output | 1 | Popped flit is on `rd_data` and `rd_last` |
| rd_data | output | 32 | Payload of the popped flit |
| rd_last | output | 1 | End marker of the popped flit |
| q_nonempty | output | 20 | One flag per queue, indexed by channel*5 + output |
| credit_ret | output | 4 | One-cycle credit pulse per channel |

## Verification
A write or pop applied before a rising edge changes `q_nonempty` and `wr_ready` right after that edge. A popped flit and its credit pulse sit in the output register for exactly the cycle after that edge. The bench drives inputs on falling edges and compares every output one falling edge later. It checks against a per-queue model that applies the pop before the write, as the design must when both hit the same queue. Directed cases cover a full pool, an empty pop, an out-of-range output and a same-cycle pop and write of a one-flit queue. Constrained random traffic that respects credits then runs between them.

// File: rtl/voq_pkg.sv
package voq_pkg;
    localparam int VC_N    = 4;
    localparam int OUT_N   = 5;
    localparam int CELL_N  = 64;
    localparam int FLIT_W  = 32;
endpackage

// File: rtl/voq_cellmem.sv
module voq_cellmem #(
    parameter int NCELL = 64,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NCELL)-1:0]  wr_cell,
    input  logic [DW:0]               wr_word,
    input  logic [$clog2(NCELL)-1:0]  rd_cell,
    output logic [DW:0]               rd_word,
    input  logic                      lka_we,
    input  logic [$clog2(NCELL)-1:0]  lka_cell,
    input  logic [$clog2(NCELL)-1:0]  lka_val,
    input  logic                      lkb_we,
    input  logic [$clog2(NCELL)-1:0]  lkb_cell,
    input  logic [$clog2(NCELL)-1:0]  lkb_val,
    input  logic [$clog2(NCELL)-1:0]  nqa_cell,
    output logic [$clog2(NCELL)-1:0]  nqa_next,
    input  logic [$clog2(NCELL)-1:0]  nqb_cell,
    output logic [$clog2(NCELL)-1:0]  nqb_next
);
    localparam int CW = $clog2(NCELL);

    typedef struct packed {
        logic [NCELL-1:0][DW:0]   word;
        logic [NCELL-1:0][CW-1:0] link;
    } mem_t;

    mem_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_en)  m_d.word[wr_cell] = wr_word;
        if (lka_we) m_d.link[lka_cell] = lka_val;
        if (lkb_we) m_d.link[lkb_cell] = lkb_val;
        rd_word  = m_q.word[rd_cell];
        nqa_next = m_q.link[nqa_cell];
        nqb_next = m_q.link[nqb_cell];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q.word <= '0;
            for (int i = 0; i < NCELL; i++) m_q.link[i] <= CW'((i + 1) % NCELL);
        end else begin
            m_q <= m_d;
        end
    end

    // R8: the two link writers never target one cell in the same cycle
    link_port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lka_we && lkb_we) |-> (lka_cell != lkb_cell));
endmodule

// File: rtl/voq_freelist.sv
module voq_freelist #(
    parameter int NCELL = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc,
    input  logic                      release_en,
    input  logic [$clog2(NCELL)-1:0]  release_cell,
    input  logic [$clog2(NCELL)-1:0]  head_next,
    output logic [$clog2(NCELL)-1:0]  head,
    output logic                      avail,
    output logic                      link_we,
    output logic [$clog2(NCELL)-1:0]  link_cell,
    output logic [$clog2(NCELL)-1:0]  link_val
);
    localparam int CW = $clog2(NCELL);
    localparam int NW = $clog2(NCELL + 1);

    typedef struct packed {
        logic [CW-1:0] head;
        logic [CW-1:0] tail;
        logic [NW-1:0] count;
    } fl_t;

    fl_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        link_we   = 1'b0;
        link_cell = s_q.tail;
        link_val  = release_cell;
        unique case ({alloc, release_en})
            2'b10: begin
                s_d.head  = head_next;
                s_d.count = s_q.count - NW'(1);
            end
            2'b01: begin
                if (s_q.count == '0) begin
                    s_d.head = release_cell;
                end else begin
                    link_we = 1'b1;
                end
                s_d.tail  = release_cell;
                s_d.count = s_q.count + NW'(1);
            end
            2'b11: begin
                s_d.head = (s_q.count == NW'(1)) ? release_cell : head_next;
                link_we  = 1'b1;
                s_d.tail = release_cell;
            end
            default: ;
        endcase
        head  = s_q.head;
        avail = (s_q.count != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.head  <= '0;
            s_q.tail  <= CW'(NCELL - 1);
            s_q.count <= NW'(NCELL);
        end else begin
            s_q <= s_d;
        end
    end

    // R7
    alloc_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (s_q.count != '0));
    // R9
    release_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_en && !alloc) |=> (s_q.count == $past(s_q.count) + NW'(1)));
endmodule

// File: rtl/voq_qtable.sv
module voq_qtable #(
    parameter int NQ    = 20,
    parameter int NCELL = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq,
    input  logic [$clog2(NQ)-1:0]     enq_q,
    input  logic [$clog2(NCELL)-1:0]  enq_cell,
    input  logic                      deq,
    input  logic [$clog2(NQ)-1:0]     deq_q,
    input  logic [$clog2(NCELL)-1:0]  deq_next,
    output logic [$clog2(NCELL)-1:0]  head_cell,
    output logic [NQ-1:0]             nonempty,
    output logic                      link_we,
    output logic [$clog2(NCELL)-1:0]  link_cell,
    output logic [$clog2(NCELL)-1:0]  link_val
);
    localparam int CW = $clog2(NCELL);

    typedef struct packed {
        logic [NQ-1:0][CW-1:0] head;
        logic [NQ-1:0][CW-1:0] tail;
        logic [NQ-1:0]         ne;
    } qt_t;

    qt_t s_d, s_q;
    logic deq_single;

    always_comb begin
        s_d        = s_q;
        link_we    = 1'b0;
        link_cell  = s_q.tail[enq_q];
        link_val   = enq_cell;
        head_cell  = s_q.head[deq_q];
        deq_single = (s_q.head[deq_q] == s_q.tail[deq_q]);
        if (deq) begin
            if (deq_single) s_d.ne[deq_q]   = 1'b0;
            else            s_d.head[deq_q] = deq_next;
        end
        if (enq) begin
            if (!s_q.ne[enq_q] || (deq && deq_q == enq_q && deq_single)) begin
                s_d.head[enq_q] = enq_cell;
                s_d.tail[enq_q] = enq_cell;
                s_d.ne[enq_q]   = 1'b1;
            end else begin
                s_d.tail[enq_q] = enq_cell;
                link_we         = 1'b1;
            end
        end
        nonempty = s_q.ne;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.head <= '0;
            s_q.tail <= '0;
            s_q.ne   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R5
    deq_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> s_q.ne[deq_q]);
    // R2
    enq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq |=> s_q.ne[$past(enq_q)]);
    // R4
    other_queue_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq && !enq && s_q.ne[(deq_q == '0) ? 1 : 0] && deq_q != '0)
        |=> s_q.ne[0] == $past(s_q.ne[0]));
endmodule

// File: rtl/voq_buffer.sv
module voq_buffer
    import voq_pkg::*;
#(
    parameter int NVC   = VC_N,
    parameter int NOUT  = OUT_N,
    parameter int NCELL = CELL_N,
    parameter int DW    = FLIT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [$clog2(NVC)-1:0]     wr_vc,
    input  logic [$clog2(NOUT)-1:0]    wr_out,
    input  logic                       wr_last,
    input  logic [DW-1:0]              wr_data,
    output logic                       wr_ready,
    input  logic                       rd_en,
    input  logic [$clog2(NVC)-1:0]     rd_vc,
    input  logic [$clog2(NOUT)-1:0]    rd_out,
    output logic                       rd_valid,
    output logic [DW-1:0]              rd_data,
    output logic                       rd_last,
    output logic [NVC*NOUT-1:0]        q_nonempty,
    output logic [NVC-1:0]             credit_ret
);
    localparam int NQ = NVC * NOUT;
    localparam int QW = $clog2(NQ);
    localparam int CW = $clog2(NCELL);

    typedef struct packed {
        logic           vld;
        logic           last;
        logic [DW-1:0]  data;
        logic [NVC-1:0] cred;
    } rdo_t;

    rdo_t o_d, o_q;

    logic          fl_avail, accept, pop;
    logic [QW-1:0] wq, rq;
    logic [CW-1:0] fl_head, fl_head_next, hd_cell, hd_next;
    logic [DW:0]   hd_word;
    logic          qt_lk_we, fl_lk_we;
    logic [CW-1:0] qt_lk_cell, qt_lk_val, fl_lk_cell, fl_lk_val;
    logic [NQ-1:0] ne;

    always_comb begin
        wq     = QW'(int'(wr_vc) * NOUT + int'(wr_out));
        rq     = QW'(int'(rd_vc) * NOUT + int'(rd_out));
        accept = wr_valid && fl_avail && (int'(wr_out) < NOUT);
        pop    = rd_en && (int'(rd_out) < NOUT) && ne[rq];
        o_d.vld  = pop;
        o_d.last = hd_word[DW];
        o_d.data = hd_word[DW-1:0];
        o_d.cred = pop ? (NVC'(1) << rd_vc) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign wr_ready   = fl_avail;
    assign rd_valid   = o_q.vld;
    assign rd_last    = o_q.last;
    assign rd_data    = o_q.data;
    assign credit_ret = o_q.cred;
    assign q_nonempty = ne;

    voq_freelist #(.NCELL(NCELL)) u_free (
        .clk(clk), .rst_n(rst_n),
        .alloc(accept), .release_en(pop), .release_cell(hd_cell),
        .head_next(fl_head_next), .head(fl_head), .avail(fl_avail),
        .link_we(fl_lk_we), .link_cell(fl_lk_cell), .link_val(fl_lk_val)
    );

    voq_qtable #(.NQ(NQ), .NCELL(NCELL)) u_qt (
        .clk(clk), .rst_n(rst_n),
        .enq(accept), .enq_q(wq), .enq_cell(fl_head),
        .deq(pop), .deq_q(rq), .deq_next(hd_next),
        .head_cell(hd_cell), .nonempty(ne),
        .link_we(qt_lk_we), .link_cell(qt_lk_cell), .link_val(qt_lk_val)
    );

    voq_cellmem #(.NCELL(NCELL), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_cell(fl_head), .wr_word({wr_last, wr_data}),
        .rd_cell(hd_cell), .rd_word(hd_word),
        .lka_we(qt_lk_we), .lka_cell(qt_lk_cell), .lka_val(qt_lk_val),
        .lkb_we(fl_lk_we), .lkb_cell(fl_lk_cell), .lkb_val(fl_lk_val),
        .nqa_cell(hd_cell), .nqa_next(hd_next),
        .nqb_cell(fl_head), .nqb_next(fl_head_next)
    );

    // R6
    credit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $onehot(credit_ret));
    // R6
    credit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (credit_ret == '0));
    // R5
    empty_pop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_out) < NOUT && !q_nonempty[rq]) |=> !rd_valid);
    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && !rd_en) |=> (!wr_ready && $stable(q_nonempty)));
endmodule

// File: tb/sim_voq_buffer.sv
module sim_voq_buffer;
    localparam int NQ = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid, wr_last, rd_en;
    logic [1:0]  wr_vc, rd_vc;
    logic [2:0]  wr_out, rd_out;
    logic [31:0] wr_data;
    logic        wr_ready, rd_valid, rd_last;
    logic [31:0] rd_data;
    logic [19:0] q_nonempty;
    logic [3:0]  credit_ret;

    always #5 clk = ~clk;

    voq_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_vc(wr_vc), .wr_out(wr_out), .wr_last(wr_last),
        .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_en(rd_en), .rd_vc(rd_vc), .rd_out(rd_out),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .q_nonempty(q_nonempty), .credit_ret(credit_ret)
    );

    int checks = 0;
    int errs   = 0;
    logic [32:0] mq [NQ][64];
    int mh [NQ];
    int mc [NQ];
    int freec;
    int cred [4];
    logic        e_vld;
    logic [32:0] e_word;
    logic [3:0]  e_cred;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] model_flags();
        logic [19:0] f = '0;
        for (int q = 0; q < NQ; q++) f[q] = (mc[q] != 0);
        return f;
    endfunction

    // one cycle: apply at a falling edge, compare one falling edge later
    task automatic step(bit wv, int wvc, int wo, bit wl, logic [31:0] wd,
                        bit rv, int rvc, int ro);
        int  rq, wq;
        bit  acc, pp;
        wr_valid = wv; wr_vc = 2'(wvc); wr_out = 3'(wo); wr_last = wl; wr_data = wd;
        rd_en = rv; rd_vc = 2'(rvc); rd_out = 3'(ro);
        rq  = rvc * 5 + ro;
        wq  = wvc * 5 + wo;
        pp  = rv && ro < 5 && mc[rq] > 0;
        acc = wv && freec > 0 && wo < 5;
        e_vld = pp; e_cred = '0; e_word = '0;
        if (pp) begin
            e_word = mq[rq][mh[rq]];
            e_cred[rvc] = 1'b1;
            mh[rq] = (mh[rq] + 1) % 64;
            mc[rq]--;
            freec++;
        end
        if (acc) begin
            mq[wq][(mh[wq] + mc[wq]) % 64] = {wl, wd};
            mc[wq]++;
            freec--;
            cred[wvc]--;
        end
        @(negedge clk);
        chk("R3 rd_valid", 64'(rd_valid), 64'(e_vld));
        if (e_vld) chk("R3 rd_word", 64'({rd_last, rd_data}), 64'(e_word));
        chk("R6 credit_ret", 64'(credit_ret), 64'(e_cred));
        chk("R2 q_nonempty", 64'(q_nonempty), 64'(model_flags()));
        chk("R7 wr_ready", 64'(wr_ready), 64'(freec > 0));
        for (int v = 0; v < 4; v++) if (credit_ret[v]) cred[v]++;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 10);
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int seed;
        logic [19:0] snap;
        seed = $urandom(32'h1c3d);
        for (int q = 0; q < NQ; q++) begin mh[q] = 0; mc[q] = 0; end
        freec = 64;
        for (int v = 0; v < 4; v++) cred[v] = 16;
        rst_n = 1'b0; wr_valid = 0; wr_vc = 0; wr_out = 0; wr_last = 0; wr_data = 0;
        rd_en = 0; rd_vc = 0; rd_out = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 wr_ready", 64'(wr_ready), 64'd1);
        chk("R1 q_nonempty", 64'(q_nonempty), 64'd0);
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 credit_ret", 64'(credit_ret), 64'd0);

        // R2 channel 1, output 3 lands in queue 8
        step(1, 1, 3, 0, 32'hA0A0_0001, 0, 0, 0);
        chk("R2 queue8", 64'(q_nonempty), 64'(20'h00100));
        step(1, 1, 3, 1, 32'hA0A0_0002, 0, 0, 0);
        step(1, 0, 0, 1, 32'hC0C0_0003, 0, 0, 0);
        // R4 pop queue 8 then queue 0; queue 8 keeps its second flit
        step(0, 0, 0, 0, 0, 1, 1, 3);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        chk("R4 queue8 kept", 64'(q_nonempty), 64'(20'h00100));
        step(0, 0, 0, 0, 0, 1, 1, 3);
        chk("R3 last marker", 64'(rd_last), 64'd1);
        // R5 pop of an empty queue
        step(0, 0, 0, 0, 0, 1, 1, 3);
        chk("R5 no data", 64'(rd_valid), 64'd0);
        chk("R5 no credit", 64'(credit_ret), 64'd0);
        // R10 out-of-range output on both sides
        snap = q_nonempty;
        step(1, 2, 6, 0, 32'hDEAD_0010, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 2, 7);
        chk("R10 flags unchanged", 64'(q_nonempty), 64'(snap));
        chk("R10 no pop", 64'(rd_valid), 64'd0);
        // R8 one-flit queue popped and written in one cycle
        step(1, 2, 4, 0, 32'hD000_0014, 0, 0, 0);
        step(1, 2, 4, 1, 32'hE000_0014, 1, 2, 4);
        chk("R8 popped old", 64'(rd_data), 64'h0000_0000_D000_0014);
        chk("R8 new kept", 64'(q_nonempty[14]), 64'd1);
        step(0, 0, 0, 0, 0, 1, 2, 4);
        chk("R8 new out", 64'(rd_data), 64'h0000_0000_E000_0014);
        idle();

        // R7 fill all cells, then try one more
        for (int i = 0; i < 64; i++) step(1, (i / 5) % 4, i % 5, i[0], 32'(i) + 32'h100, 0, 0, 0);
        chk("R7 full", 64'(wr_ready), 64'd0);
        snap = q_nonempty;
        step(1, 3, 1, 0, 32'hBAD0_BAD0, 0, 0, 0);
        chk("R7 write ignored", 64'(q_nonempty), 64'(snap));
        // R9 drain everything, then refill to full capacity
        for (int q = 0; q < NQ; q++) while (mc[q] > 0) step(0, 0, 0, 0, 0, 1, q / 5, q % 5);
        chk("R9 drained", 64'(q_nonempty), 64'd0);
        for (int i = 0; i < 64; i++) step(1, i % 4, (i * 3) % 5, 0, 32'(i) ^ 32'h5A5A, 0, 0, 0);
        chk("R9 refilled full", 64'(wr_ready), 64'd0);
        for (int q = 0; q < NQ; q++) while (mc[q] > 0) step(0, 0, 0, 0, 0, 1, q / 5, q % 5);
        for (int v = 0; v < 4; v++) cred[v] = 16;

        // constrained random traffic within channel credits
        for (int n = 0; n < 4000; n++) begin
            int  wv_c, wo_c, rv_c, ro_c;
            bit  wv, rv;
            wv_c = int'($urandom_range(0, 3));
            wo_c = int'($urandom_range(0, 5));
            wv   = ($urandom_range(0, 99) < 55) && cred[wv_c] > 0;
            rv   = ($urandom_range(0, 99) < 50);
            if ($urandom_range(0, 3) != 0) begin
                int pick = int'($urandom_range(0, NQ - 1));
                for (int k = 0; k < NQ; k++)
                    if (mc[(pick + k) % NQ] > 0) begin pick = (pick + k) % NQ; break; end
                rv_c = pick / 5; ro_c = pick % 5;
            end else begin
                rv_c = int'($urandom_range(0, 3)); ro_c = int'($urandom_range(0, 4));
            end
            step(wv, wv_c, wo_c, $urandom_range(0, 1) == 1, $urandom, rv, rv_c, ro_c);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule